// File: doc/BRIEF.md
# Adaptive Golomb Parameter Tracker

This block keeps the Golomb coding parameter k for a compression stream and adapts it from one super block to the next. When a job starts, it loads a starting k. The starting k is a 2-bit selection offset by a base that depends on the symbol width. While a super block is in progress, the block adds up the magnitudes of the signed residuals it receives and counts them.

When the super block ends, the block finds the optimal k for the statistics gathered. It then updates the current k according to the update policy fixed at job start. The policy can hold k, step k by one toward the optimum, or jump straight to the optimum. The statistics are then cleared for the next super block.

The encoder next to this block reads `k_cur` as the parameter for the super block in progress. The bit-level coding itself is done elsewhere.

Top module: `golomb_k_tracker`

## Requirements
- R1: After reset, `k_cur` is 0 and the update policy is hold, so a super-block end before any job start leaves `k_cur` at 0.
- R2: A `job_start` pulse sets `k_cur` to base + `init_sel` from the next cycle on. The base is 0 when `sym_sel` is 0 (8-bit symbols), 4 when it is 1 (12-bit), and 8 when it is 2 (16-bit). The reserved `sym_sel` value 3 is treated like 0.
- R3: A cycle with `res_vld` high adds the magnitude of the two's-complement `res_val` to the block sum and adds one to the block count. A residual in the same cycle as `blk_end` belongs to the super block that is ending. A residual in the same cycle as `job_start` is discarded.
- R4: The optimum is the smallest k in 0..15 for which count * 2^k >= sum. It is 15 when no such k exists. An empty super block gives 0.
- R5: With `upd_sel` = 2, `blk_end` sets `k_cur` to the optimum.
- R6: With `upd_sel` = 1, `blk_end` moves `k_cur` one step toward the optimum, and leaves it unchanged when it already equals the optimum.
- R7: With `upd_sel` = 0 or 3, `blk_end` leaves `k_cur` unchanged.
- R8: `blk_end` clears the sum and count, so the next super block's optimum depends only on its own residuals.
- R9: Once the count reaches 2^CNT_W-1, further residuals are dropped and do not change the sum until the next clear.
- R10: `k_cur` changes only on the clock edge that follows a `job_start` or `blk_end` cycle.
- R11: When `job_start` and `blk_end` are high in the same cycle, `job_start` wins. `k_cur` takes the starting value and the statistics are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Loads configuration and starting k |
| init_sel | input | 2 | Starting k selection |
| sym_sel | input | 2 | Symbol width: 0 = 8-bit, 1 = 12-bit, 2 = 16-bit |
| upd_sel | input | 2 | Policy: 0/3 = hold, 1 = step, 2 = jump |
| res_vld | input | 1 | Residual sample valid |
| res_val | input | MAG_W+1 | Signed residual |
| blk_end | input | 1 | Super-block end strobe |
| k_cur | output | 4 | Current Golomb parameter |

## Verification
The starting value is swept over every symbol width and every selection. This separates a wrong base from a wrong offset, and it shows whether the reserved width is handled as stated.

The jump policy is driven with blocks of one to four residuals. The magnitudes run from zero to the most negative code and the signs alternate. This exposes errors in the magnitude, the count scaling, the search order and the clamp at 15.

The step policy is walked up and then down across several blocks, and the hold policies are given large residuals. Together these separate the three policies.

Further cases target accounting errors and priority errors:
- an empty block,
- a residual in the same cycle as the block end,
- a residual in the same cycle as job start,
- a block that fills the count with zeros before large values arrive,
- a job start and a block end in the same cycle.

// File: rtl/golomb_k_tracker.sv
module golomb_k_tracker #(
  parameter int MAG_W = 16,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               job_start,
  input  logic [1:0]         init_sel,
  input  logic [1:0]         sym_sel,
  input  logic [1:0]         upd_sel,
  input  logic               res_vld,
  input  logic [MAG_W:0]     res_val,
  input  logic               blk_end,
  output logic [3:0]         k_cur
);
  localparam int SUM_W = MAG_W + 1 + CNT_W;
  localparam int CMP_W = (SUM_W > CNT_W + 16) ? SUM_W : CNT_W + 16;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [SUM_W-1:0] sum_q, sum_nx;
  logic [MAG_W:0]   mag;
  logic             take;
  logic [3:0]       base, k_start, k_opt, k_step, k_next;
  logic [15:0]      fits;

  assign mag    = res_val[MAG_W] ? (~res_val + 1'b1) : res_val;
  assign take   = res_vld && (cnt_q != CNT_MAX);
  assign cnt_nx = cnt_q + CNT_W'(take);
  assign sum_nx = sum_q + (take ? SUM_W'(mag) : '0);

  assign base    = (sym_sel == 2'd1) ? 4'd4 : (sym_sel == 2'd2) ? 4'd8 : 4'd0;
  assign k_start = base + {2'b00, init_sel};

  for (genvar i = 0; i < 16; i++) begin : g_fit
    assign fits[i] = (CMP_W'(cnt_nx) << i) >= CMP_W'(sum_nx);
  end

  always_comb begin
    k_opt = 4'd15;
    for (int i = 15; i >= 0; i--)
      if (fits[i]) k_opt = 4'(i);
  end

  assign k_step = (k_opt > k_cur) ? k_cur + 4'd1 :
                  (k_opt < k_cur) ? k_cur - 4'd1 : k_cur;

  always_comb begin
    case (mode_q)
      2'd1:    k_next = k_step;
      2'd2:    k_next = k_opt;
      default: k_next = k_cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_cur  <= '0;
      mode_q <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else if (job_start) begin
      k_cur  <= k_start;
      mode_q <= upd_sel;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else if (blk_end) begin
      k_cur  <= k_next;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else begin
      cnt_q  <= cnt_nx;
      sum_q  <= sum_nx;
    end
  end
endmodule

// File: rtl/golomb_k_tracker_chk.sv
module golomb_k_tracker_chk #(
  parameter int MAG_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           job_start,
  input logic [1:0]     init_sel,
  input logic [1:0]     sym_sel,
  input logic [1:0]     upd_sel,
  input logic           res_vld,
  input logic [MAG_W:0] res_val,
  input logic           blk_end,
  input logic [3:0]     k_cur
);
  logic [1:0] pol;

  always_ff @(posedge clk) begin
    if (!rst_n)         pol <= 2'd0;
    else if (job_start) pol <= upd_sel;
  end

  function automatic logic [3:0] start_k(logic [1:0] s, logic [1:0] i);
    return ((s == 2'd1) ? 4'd4 : (s == 2'd2) ? 4'd8 : 4'd0) + {2'b00, i};
  endfunction

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> k_cur == start_k($past(sym_sel), $past(init_sel)));

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!job_start && !blk_end) |=> $stable(k_cur));

  // R7
  hold_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!job_start && (pol == 2'd0 || pol == 2'd3)) |=> $stable(k_cur));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!job_start && pol == 2'd1) |=>
      ({1'b0, k_cur} == {1'b0, $past(k_cur)}) ||
      ({1'b0, k_cur} == {1'b0, $past(k_cur)} + 5'd1) ||
      ({1'b0, k_cur} + 5'd1 == {1'b0, $past(k_cur)}));
endmodule

bind golomb_k_tracker golomb_k_tracker_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .job_start(job_start), .init_sel(init_sel),
  .sym_sel(sym_sel), .upd_sel(upd_sel), .res_vld(res_vld), .res_val(res_val),
  .blk_end(blk_end), .k_cur(k_cur));

// File: tb/sim_golomb_k_tracker.sv
`timescale 1ns/1ps
module sim_golomb_k_tracker;
  localparam int MAG_W = 16;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic job_start = 0, res_vld = 0, blk_end = 0;
  logic [1:0] init_sel = 0, sym_sel = 0, upd_sel = 0;
  logic [MAG_W:0] res_val = '0;
  logic [3:0] k_cur;

  int vecs = 0, bad = 0;
  int m_k = 0, m_mode = 0;
  longint m_cnt = 0, m_sum = 0;

  always #10 clk = ~clk;

  golomb_k_tracker #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .init_sel(init_sel),
    .sym_sel(sym_sel), .upd_sel(upd_sel), .res_vld(res_vld), .res_val(res_val),
    .blk_end(blk_end), .k_cur(k_cur));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  function automatic int mopt(longint c, longint s);
    for (int k = 0; k < 16; k++) if ((c << k) >= s) return k;
    return 15;
  endfunction

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(string req, int got, int exp);
    vecs++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: k_cur=%0d expected %0d", req, got, exp);
    end
  endtask

  task automatic start(int s, int i, int m, bit with_res = 0, bit with_end = 0);
    @(negedge clk);
    job_start = 1; sym_sel = 2'(s); init_sel = 2'(i); upd_sel = 2'(m);
    res_vld = with_res; res_val = (MAG_W+1)'(1000); blk_end = with_end;
    @(negedge clk);
    job_start = 0; res_vld = 0; blk_end = 0;
    m_k = ((s == 1) ? 4 : (s == 2) ? 8 : 0) + i;
    m_mode = m; m_cnt = 0; m_sum = 0;
    chk(with_end ? "R11" : "R2", int'(k_cur), m_k);
  endtask

  task automatic feed(int v);
    @(negedge clk);
    res_vld = 1; res_val = (MAG_W+1)'(v);
    @(negedge clk);
    res_vld = 0;
    if (m_cnt < CMAX) begin m_cnt++; m_sum += absv(v); end
    chk("R10", int'(k_cur), m_k);
  endtask

  task automatic endblk(string req, bit with_res = 0, int v = 0);
    int o;
    @(negedge clk);
    blk_end = 1; res_vld = with_res; res_val = (MAG_W+1)'(v);
    @(negedge clk);
    blk_end = 0; res_vld = 0;
    if (with_res && m_cnt < CMAX) begin m_cnt++; m_sum += absv(v); end
    o = mopt(m_cnt, m_sum);
    if (m_mode == 2) m_k = o;
    else if (m_mode == 1) m_k = (o > m_k) ? m_k + 1 : (o < m_k) ? m_k - 1 : m_k;
    m_cnt = 0; m_sum = 0;
    chk(req, int'(k_cur), m_k);
  endtask

  initial begin
    int vals[8] = '{0, 1, 3, 7, 100, 1000, 40000, -65536};
    repeat (3) @(negedge clk);
    chk("R1", int'(k_cur), 0);
    rst_n = 1;
    feed(5000);
    endblk("R1");

    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 4; i++)
        start(s, i, 0);

    // R5 / R4 / R3: jump policy sweep over residual patterns
    start(1, 2, 2);
    for (int n = 1; n <= 4; n++)
      for (int j = 0; j < 8; j++) begin
        for (int r = 0; r < n; r++) feed((r % 2 == 1) ? -vals[j] : vals[j]);
        endblk("R5");
      end

    // R4: empty block gives 0; clamp at 15
    start(2, 3, 2);
    endblk("R4");
    feed(-65536);
    endblk("R4");

    // R6: step up then down
    start(0, 0, 1);
    for (int b = 0; b < 5; b++) begin feed(30000); endblk("R6"); end
    for (int b = 0; b < 3; b++) begin feed(0); endblk("R6"); end

    // R7: hold policies 0 and 3
    start(1, 1, 0);
    feed(60000); endblk("R7");
    start(2, 0, 3);
    feed(1); feed(-1); endblk("R7");

    // R9: count saturation drops late residuals
    start(0, 3, 2);
    for (int r = 0; r < CMAX; r++) feed(0);
    for (int r = 0; r < 4; r++) feed(1000);
    endblk("R9");

    // R3: residual alongside block end counts
    start(0, 0, 2);
    endblk("R3", 1, 1000);

    // R3: residual alongside job start discarded
    start(2, 2, 2, 1);
    endblk("R3");

    // R8: statistics clear between blocks
    feed(20000); endblk("R8");
    endblk("R8");

    // R11: job start wins over block end
    feed(50000);
    start(1, 3, 2, 0, 1);
    endblk("R11");

    summary();
  end
endmodule